// File: doc/BRIEF.md
# Locality-Score Load Throttling Scheduler

This block picks one wavefront per cycle to issue from a pool of wavefront contexts sharing a first-level data cache. Each context carries a small locality score. Whenever the lost-locality detector reports a context, that context's score jumps up. The block treats the scores of the active contexts as a stack, with the oldest context at the bottom. Any context whose share of the stack reaches above a cutoff is barred from issuing loads. Its non-load instructions still issue. Fewer contexts then contend for the cache until the scores decay back down.

Age is fixed by index: context 0 is the oldest and a higher index is younger. Issue follows a greedy-then-oldest rule over the contexts that are eligible this cycle. The grant is combinational from the present inputs and the registered state, so a scheduler stage can use it in the same cycle.

Top module: `lls_throttle_sched`

## Requirements
- R1: `grant_o` is zero or one-hot, and a bit is set only for a context that is both active and ready in that cycle.
- R2: If the context granted in the previous grant cycle is still eligible, it is granted again, whatever older contexts are ready.
- R3: Otherwise the lowest-index eligible context is granted. A context is eligible when it is active, ready, and either its instruction is not a load (`is_load_i` bit 0) or it is not throttled.
- R4: After reset every score equals the base value 1, no previous grant is remembered, and with nothing ready the grant is zero.
- R5: A lost-locality event (`loss_valid_i` high, `loss_wid_i` = index) adds 16 to that context's score at the next clock edge, saturating at 255. It takes precedence over decay in the same cycle.
- R6: An inactive context holds the base score, ignores events, adds nothing to the stack and is never granted.
- R7: Context i is throttled when the sum of the scores of all active contexts with index at most i exceeds 64 times the number of active contexts.
- R8: Throttling blocks only loads: a throttled ready context with a non-load instruction stays eligible.
- R9: The lowest-index active context is never throttled.
- R10: Every 64 clock cycles each active context whose score is above 1 loses one unit, and no score falls below 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| active_i | input | 32 | Context holds a live wavefront |
| ready_i | input | 32 | Context has an instruction ready to issue |
| is_load_i | input | 32 | Ready instruction of the context is a load |
| loss_valid_i | input | 1 | Lost-locality event present this cycle |
| loss_wid_i | input | 5 | Context index of the event |
| grant_o | output | 32 | One-hot issue grant, zero when none |

## Verification
A wrong score shows at the ports only through the throttling decision. A score that missed an increment or wrapped instead of saturating makes a load grant appear or vanish right after the event that crosses the cutoff. A stuck decay counter shows after a wait of a few periods, when a load that should have been freed stays blocked. A bad greedy register shows in the first cycle where an older context becomes ready beside the one last granted.

// File: rtl/lls_pkg.sv
package lls_pkg;

  localparam int unsigned SCORE_W = 8;

  typedef logic [SCORE_W-1:0] score_t;

  // Next score of one active context: a bump wins over decay, bump saturates.
  function automatic score_t score_step(input score_t cur, input logic bump,
                                        input logic tick, input score_t inc,
                                        input score_t base);
    logic [SCORE_W:0] wide;
    score_t nxt;
    nxt = cur;
    if (bump) begin
      wide = {1'b0, cur} + {1'b0, inc};
      nxt  = wide[SCORE_W] ? '1 : wide[SCORE_W-1:0];
    end else if (tick && (cur > base)) begin
      nxt = cur - score_t'(1);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/lls_score_bank.sv
module lls_score_bank
  import lls_pkg::*;
#(
  parameter int unsigned NUM_WF       = 32,
  parameter int unsigned BUMP         = 16,
  parameter int unsigned BASE         = 1,
  parameter int unsigned DECAY_PERIOD = 64,
  localparam int unsigned WID_W = $clog2(NUM_WF),
  localparam int unsigned DC_W  = $clog2(DECAY_PERIOD)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_WF-1:0]                active_i,
  input  logic                             ev_valid_i,
  input  logic [WID_W-1:0]                 ev_wid_i,
  output logic [NUM_WF-1:0][SCORE_W-1:0]   score_o
);

  logic [DC_W-1:0] decay_cnt_q;
  logic            decay_tick;
  logic [NUM_WF-1:0] bump;

  assign decay_tick = (decay_cnt_q == DC_W'(DECAY_PERIOD - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) decay_cnt_q <= '0;
    else         decay_cnt_q <= decay_tick ? '0 : decay_cnt_q + DC_W'(1);
  end

  for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
    assign bump[w] = ev_valid_i && (ev_wid_i == WID_W'(w)) && active_i[w];

    always_ff @(posedge clk_i) begin
      if (!rst_ni || !active_i[w]) score_o[w] <= score_t'(BASE);
      else score_o[w] <= score_step(score_o[w], bump[w], decay_tick,
                                    score_t'(BUMP), score_t'(BASE));
    end

    // R5: a bump on a full score keeps it full
    p_sat_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bump[w] && score_o[w] == '1) |=> (score_o[w] == '1));

    // R5: a bump with headroom adds exactly the increment
    p_bump_add_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bump[w] && ({1'b0, score_o[w]} + (SCORE_W+1)'(BUMP) <= (SCORE_W+1)'(255)))
      |=> (score_o[w] == $past(score_o[w]) + score_t'(BUMP)));

    // R10: decay takes one unit from an active score above base
    p_decay_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i[w] && !bump[w] && decay_tick && score_o[w] > score_t'(BASE))
      |=> (score_o[w] == $past(score_o[w]) - score_t'(1)));

    // R10: no score drops under the base
    p_floor_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      score_o[w] >= score_t'(BASE));

    // R6: an inactive context sits at base on the next cycle
    p_idle_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_i[w] |=> (score_o[w] == score_t'(BASE)));
  end

endmodule

// File: rtl/lls_stack_throttle.sv
module lls_stack_throttle
  import lls_pkg::*;
#(
  parameter int unsigned NUM_WF     = 32,
  parameter int unsigned CUT_PER_WF = 64,
  localparam int unsigned SUM_W = SCORE_W + $clog2(NUM_WF) + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WF-1:0]              active_i,
  input  logic [NUM_WF-1:0][SCORE_W-1:0] score_i,
  output logic [NUM_WF-1:0]              throttle_o,
  output logic [NUM_WF-1:0]              oldest_o
);

  logic [NUM_WF-1:0][SUM_W-1:0] top_sum;
  logic [SUM_W-1:0]             cutoff;

  // Running height of the stack, oldest context at the bottom.
  always_comb begin
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_WF; i++) begin
      if (active_i[i]) acc = acc + SUM_W'(score_i[i]);
      top_sum[i] = acc;
    end
  end

  assign cutoff   = SUM_W'(CUT_PER_WF) * SUM_W'($countones(active_i));
  assign oldest_o = active_i & (~active_i + NUM_WF'(1));

  for (genvar i = 0; i < NUM_WF; i++) begin : g_thr
    localparam logic [NUM_WF-1:0] YOUNGER = {NUM_WF{1'b1}} << (i + 1);

    assign throttle_o[i] = active_i[i] && !oldest_o[i] && (top_sum[i] > cutoff);

    // R7: once a context is over the cutoff, every younger active one is too
    p_stack_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      throttle_o[i] |-> ((active_i & ~throttle_o & YOUNGER) == '0));
  end

endmodule

// File: rtl/lls_issue_pick.sv
module lls_issue_pick #(
  parameter int unsigned NUM_WF = 32,
  localparam int unsigned WID_W = $clog2(NUM_WF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WF-1:0] active_i,
  input  logic [NUM_WF-1:0] ready_i,
  input  logic [NUM_WF-1:0] is_load_i,
  input  logic [NUM_WF-1:0] throttle_i,
  output logic [NUM_WF-1:0] grant_o
);

  logic [NUM_WF-1:0] eligible;
  logic              last_vld_q;
  logic [WID_W-1:0]  last_idx_q;

  function automatic logic [WID_W-1:0] index_of(input logic [NUM_WF-1:0] oh);
    logic [WID_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NUM_WF; i++) if (oh[i]) idx = WID_W'(i);
    return idx;
  endfunction

  assign eligible = active_i & ready_i & ~(is_load_i & throttle_i);

  always_comb begin
    if (last_vld_q && eligible[last_idx_q]) begin
      grant_o = '0;
      grant_o[last_idx_q] = 1'b1;
    end else begin
      grant_o = eligible & (~eligible + NUM_WF'(1));
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      last_vld_q <= 1'b0;
      last_idx_q <= '0;
    end else if (|grant_o) begin
      last_vld_q <= 1'b1;
      last_idx_q <= index_of(grant_o);
    end
  end

  for (genvar i = 0; i < NUM_WF; i++) begin : g_keep
    // R2: a granted context still eligible next cycle keeps the grant
    p_greedy_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[i] |=> (!eligible[i] || grant_o[i]));
  end

endmodule

// File: rtl/lls_throttle_sched.sv
module lls_throttle_sched
  import lls_pkg::*;
#(
  parameter int unsigned NUM_WF       = 32,
  parameter int unsigned BUMP         = 16,
  parameter int unsigned BASE         = 1,
  parameter int unsigned DECAY_PERIOD = 64,
  parameter int unsigned CUT_PER_WF   = 64,
  localparam int unsigned WID_W = $clog2(NUM_WF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WF-1:0] active_i,
  input  logic [NUM_WF-1:0] ready_i,
  input  logic [NUM_WF-1:0] is_load_i,
  input  logic              loss_valid_i,
  input  logic [WID_W-1:0]  loss_wid_i,
  output logic [NUM_WF-1:0] grant_o
);

  logic [NUM_WF-1:0][SCORE_W-1:0] score;
  logic [NUM_WF-1:0]              throttle;
  logic [NUM_WF-1:0]              oldest;

  lls_score_bank #(
    .NUM_WF(NUM_WF), .BUMP(BUMP), .BASE(BASE), .DECAY_PERIOD(DECAY_PERIOD)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i),
    .ev_valid_i(loss_valid_i), .ev_wid_i(loss_wid_i), .score_o(score)
  );

  lls_stack_throttle #(
    .NUM_WF(NUM_WF), .CUT_PER_WF(CUT_PER_WF)
  ) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i), .score_i(score),
    .throttle_o(throttle), .oldest_o(oldest)
  );

  lls_issue_pick #(.NUM_WF(NUM_WF)) u_pick (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i), .ready_i(ready_i),
    .is_load_i(is_load_i), .throttle_i(throttle), .grant_o(grant_o)
  );

  // R1: at most one grant, and only to an active ready context
  p_grant_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~(active_i & ready_i)) == '0));

  // R8: a throttled load never issues
  p_load_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & is_load_i & throttle) == '0);

  // R8: if the only ready contexts carry non-loads, one of them issues
  p_nonload_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((active_i & ready_i & ~is_load_i) != '0) |-> (grant_o != '0));

  // R9: the oldest active context is never held back
  p_oldest_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttle & oldest) == '0);

endmodule

// File: tb/tb_lls_throttle_sched.sv
module tb_lls_throttle_sched;

  localparam int unsigned N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  active, ready, is_load, grant;
  logic          loss_valid;
  logic [4:0]    loss_wid;
  int            total = 0;
  int            bad = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  lls_throttle_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active), .ready_i(ready),
    .is_load_i(is_load), .loss_valid_i(loss_valid), .loss_wid_i(loss_wid),
    .grant_o(grant)
  );

  // {active, ready, is_load, expected grant}, applied one per cycle in order
  localparam logic [127:0] VEC [0:9] = '{
    {32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000},
    {32'hFFFFFFFF, 32'h00000006, 32'h00000006, 32'h00000002},
    {32'hFFFFFFFF, 32'h00000007, 32'h00000000, 32'h00000002},
    {32'hFFFFFFFF, 32'h00000005, 32'h00000005, 32'h00000001},
    {32'hFFFFFFFF, 32'h00000008, 32'h00000000, 32'h00000008},
    {32'hFFFFFFFF, 32'h00000009, 32'h00000009, 32'h00000008},
    {32'hFFFFFFF7, 32'h00000009, 32'h00000000, 32'h00000001},
    {32'hFFFFFFFF, 32'h80000000, 32'h80000000, 32'h80000000},
    {32'hFFFFFFFF, 32'h80000001, 32'h00000000, 32'h80000000},
    {32'h7FFFFFFF, 32'h80000000, 32'h00000000, 32'h00000000}
  };

  task automatic check(input string tag, input logic [N-1:0] exp);
    total++;
    if (grant !== exp) begin
      bad++;
      $display("FAIL %s grant=%h expected=%h", tag, grant, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; active = '0; ready = '0; is_load = '0;
    loss_valid = 1'b0; loss_wid = '0;
    cycles(2);
    rst_n = 1'b1;
  endtask

  task automatic events(input int wid, input int n);
    loss_valid = 1'b1; loss_wid = 5'(wid);
    cycles(n);
    loss_valid = 1'b0;
  endtask

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] r,
                       input logic [N-1:0] l);
    active = a; ready = r; is_load = l;
    #5;
  endtask

  initial begin
    rst_n = 1'b0; active = '0; ready = '0; is_load = '0;
    loss_valid = 1'b0; loss_wid = '0;

    // R4: state right after reset
    do_reset();
    apply('1, '0, '0);
    check("R4 idle after reset", '0);
    apply('1, '1, '1);
    check("R4 base scores leave all loads free", 32'h1);

    // R1 R2 R3 R6: table walk over grant ordering
    do_reset();
    for (int k = 0; k < 10; k++) begin
      apply(VEC[k][127:96], VEC[k][95:64], VEC[k][63:32]);
      check($sformatf("R1 R2 R3 R6 vector %0d", k), VEC[k][31:0]);
      @(negedge clk);
    end

    // R5 R7: seven bumps keep context 1 under the cutoff of 128
    do_reset();
    apply(32'h3, '0, '0);
    events(1, 7);
    apply(32'h3, 32'h2, 32'h2);
    check("R5 R7 stack 114 not above 128", 32'h2);
    @(negedge clk);
    ready = '0;
    // the eighth bump lifts the stack to 130
    events(1, 1);
    apply(32'h3, 32'h2, 32'h2);
    check("R7 stack 130 blocks load", 32'h0);
    apply(32'h3, 32'h2, 32'h0);
    check("R8 non-load of throttled context", 32'h2);
    @(negedge clk);
    apply(32'h3, 32'h3, 32'h3);
    check("R9 oldest load free", 32'h1);
    @(negedge clk);
    ready = '0;
    cycles(200);
    apply(32'h3, 32'h2, 32'h2);
    check("R10 decay frees load", 32'h2);

    // R5: saturation at 255, then long decay
    do_reset();
    apply(32'h3, '0, '0);
    events(1, 20);
    cycles(64 * 120);
    apply(32'h3, 32'h2, 32'h2);
    check("R5 saturated score still throttles", 32'h0);
    ready = '0;
    cycles(64 * 14);
    apply(32'h3, 32'h2, 32'h2);
    check("R10 saturated score decays below cutoff", 32'h2);

    // R6: events to an inactive context are dropped
    do_reset();
    apply(32'h2, '0, '0);
    events(0, 10);
    apply(32'h3, 32'h2, 32'h2);
    check("R6 inactive ignored events", 32'h2);
    apply(32'h2, 32'h1, 32'h0);
    check("R6 inactive not granted", 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule